// File: doc/BRIEF.md
# Wall-Following Robot Controller

This block steers a small maze-walking robot by keeping its right feeler against a wall. Two contact sensors report touch on the left and right. Each cycle the block drives a command word with three bits: advance one step, rotate a small increment anticlockwise, and rotate a small increment clockwise. The robot's mechanics and the maze lie outside the block.

The controller is a Moore machine with four modes. The outputs depend only on the registered mode. The modes are: cruising straight until first contact; backing off by turning left while anything touches; seeking the wall with a forward-right nudge; and hugging it with a forward-left nudge. The corner case of stepping and turning right until a perpendicular wall is reached gives the same outputs and successors as wall seeking, so it is merged into the seeking mode. A step-enable input lets the actuator pace the machine: the mode advances only on enabled cycles.

The mode register has two bits, and all four codes are legal. The machine therefore cannot reach an undefined code.

Top module: `wallbot_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the block in the cruise mode (code 00). While reset is held and on the cycle after it, the outputs read fwd=1, tl=0, tr=0.
- R2: On a clock edge with step_en low and reset low, the mode and the outputs keep their values whatever the sensors show.
- R3: From cruise (code 00), an enabled edge with either sensor high moves to back-off (code 01). With both sensors low the mode stays in cruise.
- R4: From back-off, an enabled edge with both sensors low moves to seek (code 10). Any contact keeps the mode in back-off.
- R5: From seek, an enabled edge with the left sensor high moves to back-off. The left sensor has priority over the right. With only the right sensor high the mode moves to hug (code 11). With no contact the mode stays in seek.
- R6: From hug, an enabled edge with the left sensor high moves to back-off. Otherwise, a low right sensor returns the mode to seek, and a high right sensor keeps it in hug.
- R7: The outputs {fwd,tl,tr} are 100 in cruise, 010 in back-off, 101 in seek and 110 in hug. tl and tr are never high together.
- R8: The outputs are a function of the registered mode only. A change on the sensors alone never changes them before the next enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance the mode on this edge |
| sense_l | input | 1 | Left feeler touching |
| sense_r | input | 1 | Right feeler touching |
| cmd_fwd | output | 1 | Step forward |
| cmd_tl | output | 1 | Small anticlockwise turn |
| cmd_tr | output | 1 | Small clockwise turn |

## Verification
The block has no tunable parameters, so the bench builds it in its single configuration. Each of the four modes has its own output pattern, so the bench can follow the mode entirely from the ports. Directed sequences walk every transition, including the seek mode's case with both sensors high, where the left sensor wins. A long pseudo-random run with step_en toggling then covers all sixteen combinations of mode and sensors, with and without the enable, and includes stretches where the sensors change while the enable is low.

// File: rtl/wallbot_pkg.sv
package wallbot_pkg;

    typedef enum logic [1:0] {
        ST_CRUISE  = 2'b00,
        ST_BACKOFF = 2'b01,
        ST_SEEK    = 2'b10,
        ST_HUG     = 2'b11
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    typedef struct packed {
        logic left;
        logic right;
    } touch_t;

    typedef struct packed {
        logic fwd;
        logic tl;
        logic tr;
    } drive_t;

    localparam int DRIVE_W = $bits(drive_t);

    // Successor of a mode for one sensor sample.
    function automatic mode_t mode_next(mode_t cur, touch_t t);
        mode_t nxt;
        nxt = cur;
        unique case (cur)
            ST_CRUISE:  if (t.left || t.right) nxt = ST_BACKOFF;
            ST_BACKOFF: if (!t.left && !t.right) nxt = ST_SEEK;
            ST_SEEK: begin
                if (t.left)       nxt = ST_BACKOFF;
                else if (t.right) nxt = ST_HUG;
            end
            ST_HUG: begin
                if (t.left)        nxt = ST_BACKOFF;
                else if (!t.right) nxt = ST_SEEK;
            end
            default: nxt = ST_CRUISE;
        endcase
        return nxt;
    endfunction

    // Moore output pattern of a mode.
    function automatic drive_t mode_drive(mode_t m);
        drive_t d;
        unique case (m)
            ST_CRUISE:  d = '{fwd: 1'b1, tl: 1'b0, tr: 1'b0};
            ST_BACKOFF: d = '{fwd: 1'b0, tl: 1'b1, tr: 1'b0};
            ST_SEEK:    d = '{fwd: 1'b1, tl: 1'b0, tr: 1'b1};
            ST_HUG:     d = '{fwd: 1'b1, tl: 1'b1, tr: 1'b0};
            default:    d = '{fwd: 1'b1, tl: 1'b0, tr: 1'b0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/wb_next_mode.sv
module wb_next_mode
    import wallbot_pkg::*;
(
    input  mode_t  cur,
    input  touch_t touch,
    output mode_t  nxt
);
    always_comb nxt = mode_next(cur, touch);
endmodule

// File: rtl/wb_mode_reg.sv
module wb_mode_reg
    import wallbot_pkg::*;
#(
    parameter mode_t RESET_MODE = ST_CRUISE
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  mode_t nxt,
    output mode_t cur
);
    always_ff @(posedge clk) begin
        if (rst)     cur <= RESET_MODE;
        else if (en) cur <= nxt;
    end
endmodule

// File: rtl/wb_drive_decode.sv
module wb_drive_decode
    import wallbot_pkg::*;
(
    input  mode_t  cur,
    output drive_t drive
);
    always_comb drive = mode_drive(cur);
endmodule

// File: rtl/wallbot_ctrl.sv
module wallbot_ctrl
    import wallbot_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step_en,
    input  logic sense_l,
    input  logic sense_r,
    output logic cmd_fwd,
    output logic cmd_tl,
    output logic cmd_tr
);
    touch_t touch;
    mode_t  mode_q;
    mode_t  mode_d;
    drive_t drive;

    assign touch = '{left: sense_l, right: sense_r};

    wb_next_mode i_next (
        .cur   (mode_q),
        .touch (touch),
        .nxt   (mode_d)
    );

    wb_mode_reg #(.RESET_MODE(ST_CRUISE)) i_reg (
        .clk (clk),
        .rst (rst),
        .en  (step_en),
        .nxt (mode_d),
        .cur (mode_q)
    );

    wb_drive_decode i_dec (
        .cur   (mode_q),
        .drive (drive)
    );

    assign cmd_fwd = drive.fwd;
    assign cmd_tl  = drive.tl;
    assign cmd_tr  = drive.tr;
endmodule

// File: rtl/wallbot_ctrl_chk.sv
module wallbot_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       step_en,
    input logic       sense_l,
    input logic       sense_r,
    input logic [1:0] mode,
    input logic       cmd_fwd,
    input logic       cmd_tl,
    input logic       cmd_tr
);
    logic rst_seen = 1'b0;
    always_ff @(posedge clk) rst_seen <= rst;

    always @(negedge clk) begin
        if (rst_seen) begin
            AST_RESET_CRUISE: assert (mode == 2'b00 && cmd_fwd && !cmd_tl && !cmd_tr); // R1
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(mode)); // R2

    AST_CRUISE_CONTACT: assert property (@(posedge clk) disable iff (rst)
        (step_en && mode == 2'b00 && (sense_l || sense_r)) |=> mode == 2'b01); // R3

    AST_BACKOFF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (step_en && mode == 2'b01 && !sense_l && !sense_r) |=> mode == 2'b10); // R4

    AST_SEEK_LEFT_WINS: assert property (@(posedge clk) disable iff (rst)
        (step_en && mode == 2'b10 && sense_l) |=> mode == 2'b01); // R5

    AST_HUG_LOST_WALL: assert property (@(posedge clk) disable iff (rst)
        (step_en && mode == 2'b11 && !sense_l && !sense_r) |=> mode == 2'b10); // R6

    AST_ONE_TURN: assert property (@(posedge clk) disable iff (rst)
        !(cmd_tl && cmd_tr)); // R7

    AST_MOORE_OUT: assert property (@(posedge clk) disable iff (rst)
        $stable(mode) |-> ($stable(cmd_fwd) && $stable(cmd_tl) && $stable(cmd_tr))); // R8
endmodule

bind wallbot_ctrl wallbot_ctrl_chk i_chk (
    .clk     (clk),
    .rst     (rst),
    .step_en (step_en),
    .sense_l (sense_l),
    .sense_r (sense_r),
    .mode    (mode_q),
    .cmd_fwd (cmd_fwd),
    .cmd_tl  (cmd_tl),
    .cmd_tr  (cmd_tr)
);

// File: tb/test_wallbot_ctrl.sv
module test_wallbot_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic step_en = 1'b0;
    logic sense_l = 1'b0;
    logic sense_r = 1'b0;
    logic cmd_fwd, cmd_tl, cmd_tr;

    int n_run = 0;
    int n_fail = 0;
    int ref_mode = 0;   // 0 cruise, 1 back-off, 2 seek, 3 hug
    bit done = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    wallbot_ctrl i_wallbot_ctrl (
        .clk(clk), .rst(rst), .step_en(step_en),
        .sense_l(sense_l), .sense_r(sense_r),
        .cmd_fwd(cmd_fwd), .cmd_tl(cmd_tl), .cmd_tr(cmd_tr)
    );

    function automatic logic [2:0] expect_out(int m);
        case (m)
            0: return 3'b100;
            1: return 3'b010;
            2: return 3'b101;
            default: return 3'b110;
        endcase
    endfunction

    function automatic string tag_for(bit r, bit e, int m);
        if (r) return "R1";
        if (!e) return "R2,R8";
        case (m)
            0: return "R3,R7";
            1: return "R4,R7";
            2: return "R5,R7";
            default: return "R6,R7";
        endcase
    endfunction

    // Called at a falling edge: drive, clock, update model, check at next fall.
    task automatic cyc(input bit r, input bit e, input bit l, input bit rr);
        string tag;
        logic [2:0] got;
        rst = r; step_en = e; sense_l = l; sense_r = rr;
        tag = tag_for(r, e, ref_mode);
        @(posedge clk);
        if (r) ref_mode = 0;
        else if (e) begin
            case (ref_mode)
                0: if (l || rr) ref_mode = 1;
                1: if (!l && !rr) ref_mode = 2;
                2: if (l) ref_mode = 1; else if (rr) ref_mode = 3;
                default: if (l) ref_mode = 1; else if (!rr) ref_mode = 2;
            endcase
        end
        @(negedge clk);
        got = {cmd_fwd, cmd_tl, cmd_tr};
        n_run++;
        if (got !== expect_out(ref_mode)) begin
            n_fail++;
            $display("FAIL %s: outputs %b expected %b (model mode %0d)",
                     tag, got, expect_out(ref_mode), ref_mode);
        end
    endtask

    // Sensors wiggle with enable low; outputs must not move (R8, R2).
    task automatic wiggle_idle();
        for (int k = 0; k < 4; k++) begin
            sense_l = k[0]; sense_r = k[1]; step_en = 1'b0;
            #1;
            n_run++;
            if ({cmd_fwd, cmd_tl, cmd_tr} !== expect_out(ref_mode)) begin
                n_fail++;
                $display("FAIL R8: outputs %b expected %b after sensor change",
                         {cmd_fwd, cmd_tl, cmd_tr}, expect_out(ref_mode));
            end
        end
        cyc(0, 0, 1, 1);
    endtask

    initial begin
        @(negedge clk);
        cyc(1, 0, 1, 1);            // R1 reset state
        cyc(1, 1, 1, 0);            // R1 reset beats enable
        cyc(0, 1, 0, 0);            // R3 stay in cruise
        cyc(0, 1, 0, 1);            // R3 right contact -> back-off
        cyc(0, 1, 1, 0);            // R4 still touching
        cyc(0, 1, 0, 0);            // R4 clear -> seek
        cyc(0, 1, 0, 0);            // R5 stay
        cyc(0, 1, 1, 1);            // R5 left wins -> back-off
        cyc(0, 1, 0, 0);            // to seek
        cyc(0, 1, 0, 1);            // R5 right only -> hug
        cyc(0, 1, 0, 1);            // R6 stay
        wiggle_idle();              // R2, R8 in hug
        cyc(0, 0, 1, 0);            // R2 no advance
        cyc(0, 1, 0, 0);            // R6 -> seek
        cyc(0, 1, 0, 1);            // -> hug
        cyc(0, 1, 1, 1);            // R6 left -> back-off
        cyc(0, 1, 0, 0);            // seek
        cyc(1, 0, 0, 0);            // R1 reset from seek
        cyc(0, 1, 1, 0);            // R3 left contact
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[7:0] == 8'h00, lfsr[3] | lfsr[9], lfsr[1], lfsr[5]);
            if (lfsr[11:8] == 4'hF) wiggle_idle();
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule